// File: doc/BRIEF.md
# Symmetric Pipelined FIR Filter

This block is a fully parallel direct-form FIR filter with a fixed, symmetric set of coefficients. It accepts one signed sample per clock when the input strobe is high and produces one full-precision filtered result per clock, marked by an output strobe. Two taps that share a coefficient are added together before the multiply, so a 60-tap filter needs only 30 multipliers. The 30 products are then summed by a binary adder tree in which every level is registered.

The sample history advances only on cycles where the input strobe is high, so gaps in the input stream leave the filter state untouched. The output strobe is the input strobe delayed by the fixed pipeline depth. That depth is nine register stages: the head of the delay line, the pre-adder, the multiplier, five tree levels and the output register. The block has no state machine. Its whole schedule is this fixed pipeline, which a single valid shift register tracks.

The coefficient for half-index i (0 ≤ i < TAPS/2) is defined as follows. Index 0 is −1 (0xFFFF). The last index, TAPS/2−1, is 10773 (0x2A15). Every other index takes the value ((97·i² + 331·i + 17) mod 4097) − 2048. Tap k and tap TAPS−1−k use the same coefficient.

Top module: `symfir_top`

## Requirements
- R1: A sample presented with `din_vld` high before clock edge E yields its result on `dout`, with `dout_vld` high, right after edge E+8, which is nine register stages. `dout_vld` is never high earlier than nine edges after reset release.
- R2: After reset, a single sample of value 1 followed by zeros produces an output sequence equal to the 60 coefficients, tap 0 first.
- R3: Coefficients follow the formula in the description and are symmetric: tap k equals tap 59−k, the outer taps are −1 and the two centre taps are 10773.
- R4: Arithmetic is two's complement and keeps full precision. With the history filled with −32768 or with 32767, `dout` equals the exact 38-bit sum, with no wrap.
- R5: A cycle with `din_vld` low does not enter the history, whatever `din` holds, and produces no output strobe for that cycle.
- R6: While `rst` is high at a clock edge, the delay line, all pipeline registers and the valid pipeline clear. After reset, `dout` is 0, `dout_vld` is 0, and later results reflect an all-zero history.
- R7: Samples can be presented on every consecutive clock, and each one produces its own output nine edges later.
- R8: For any input sequence, each valid output equals the sum over k of coef[k]·x[n−k], where x counts valid samples only.
- R9: Once nine or more edges have passed since the last valid sample, `dout` stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 16 | Signed input sample |
| din_vld | input | 1 | High when `din` carries a sample |
| dout | output | 38 | Signed full-precision filter output |
| dout_vld | output | 1 | High when `dout` carries a new result |

## Verification
The assertions watch, on every cycle, that the output strobe tracks the input strobe across the nine-stage pipeline, that no strobe appears too early after reset, that reset leaves the output cleared, and that the output holds steady once the input has been idle long enough. Whether the numbers are right can only be shown by the bench scenarios. These are the impulse response against the coefficient formula and its mirror symmetry, extreme-value histories that stress the 38-bit width, and random streams both back-to-back and gapped with junk on `din`, all compared against an arithmetic convolution.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

    // Smallest r with 2**r >= v.
    function automatic int ceil_log2(input int v);
        int r;
        r = 0;
        for (int b = 0; b < 31; b++) begin
            if ((1 << b) < v) r = b + 1;
        end
        return r;
    endfunction

    // Number of partial sums at a given adder-tree level.
    function automatic int nodes_at(input int leaves, input int lvl);
        return (leaves + (1 << lvl) - 1) >> lvl;
    endfunction

    // Coefficient for half-index idx of a filter with `half` coefficient pairs.
    function automatic int coef_half(input int idx, input int half);
        if (idx == 0) return -1;
        if (idx == half - 1) return 10773;
        return ((97 * idx * idx + 331 * idx + 17) % 4097) - 2048;
    endfunction

endpackage

// File: rtl/symfir_taps.sv
module symfir_taps
    import symfir_pkg::*;
#(
    parameter int TAPS   = 60,
    parameter int DATA_W = 16,
    localparam int HALF  = TAPS / 2,
    localparam int PRE_W = DATA_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] din,
    input  logic                     din_vld,
    output logic signed [PRE_W-1:0]  pre_q [HALF]
);

    // Sample history; entry 0 doubles as the input capture register.
    logic signed [DATA_W-1:0] line_q [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TAPS; k++) line_q[k] <= '0;
        end else if (din_vld) begin
            line_q[0] <= din;
            for (int k = 1; k < TAPS; k++) line_q[k] <= line_q[k-1];
        end
    end

    // Fold: taps j and TAPS-1-j share one coefficient.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < HALF; j++) pre_q[j] <= '0;
        end else begin
            for (int j = 0; j < HALF; j++)
                pre_q[j] <= PRE_W'(line_q[j]) + PRE_W'(line_q[TAPS-1-j]);
        end
    end

endmodule

// File: rtl/symfir_mult.sv
module symfir_mult
    import symfir_pkg::*;
#(
    parameter int HALF   = 30,
    parameter int PRE_W  = 17,
    parameter int COEF_W = 16,
    localparam int PROD_W = PRE_W + COEF_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [PRE_W-1:0]  pre_i  [HALF],
    output logic signed [PROD_W-1:0] prod_q [HALF]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < HALF; j++) prod_q[j] <= '0;
        end else begin
            for (int j = 0; j < HALF; j++)
                prod_q[j] <= PROD_W'(pre_i[j]) *
                             PROD_W'(COEF_W'(coef_half(j, HALF)));
        end
    end

endmodule

// File: rtl/symfir_tree.sv
module symfir_tree
    import symfir_pkg::*;
#(
    parameter int LEAVES = 30,
    parameter int IN_W   = 33,
    parameter int LEVELS = 5,
    parameter int ACC_W  = 38
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [IN_W-1:0]  leaf [LEAVES],
    output logic signed [ACC_W-1:0] root
);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int CNT  = nodes_at(LEAVES, l);
        localparam int PCNT = (l == 0) ? LEAVES : nodes_at(LEAVES, l - 1);
        for (genvar i = 0; i < CNT; i++) begin : g_node
            logic signed [ACC_W-1:0] q;
            if (l == 0) begin : g_leaf
                assign q = ACC_W'(leaf[i]);
            end else if (2 * i + 1 < PCNT) begin : g_pair
                always_ff @(posedge clk) begin
                    if (rst) q <= '0;
                    else     q <= g_lvl[l-1].g_node[2*i].q + g_lvl[l-1].g_node[2*i+1].q;
                end
            end else begin : g_pass
                // Unpaired sum: register only, keeping all paths equal length.
                always_ff @(posedge clk) begin
                    if (rst) q <= '0;
                    else     q <= g_lvl[l-1].g_node[2*i].q;
                end
            end
        end
    end

    assign root = g_lvl[LEVELS].g_node[0].q;

endmodule

// File: rtl/symfir_top.sv
module symfir_top
    import symfir_pkg::*;
#(
    parameter int TAPS   = 60,
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int OUT_W  = 38
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] din,
    input  logic                     din_vld,
    output logic signed [OUT_W-1:0]  dout,
    output logic                     dout_vld
);

    localparam int HALF   = TAPS / 2;
    localparam int PRE_W  = DATA_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;
    localparam int LEVELS = ceil_log2(HALF);
    localparam int ACC_W  = PROD_W + LEVELS;
    // line head + pre-add + multiply + tree levels + output register
    localparam int LAT    = 4 + LEVELS;

    logic signed [PRE_W-1:0]  pre  [HALF];
    logic signed [PROD_W-1:0] prod [HALF];
    logic signed [ACC_W-1:0]  root;
    logic [LAT-1:0]           vpipe_q;

    symfir_taps #(
        .TAPS   (TAPS),
        .DATA_W (DATA_W)
    ) u_taps (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .din_vld (din_vld),
        .pre_q   (pre)
    );

    symfir_mult #(
        .HALF   (HALF),
        .PRE_W  (PRE_W),
        .COEF_W (COEF_W)
    ) u_mult (
        .clk    (clk),
        .rst    (rst),
        .pre_i  (pre),
        .prod_q (prod)
    );

    symfir_tree #(
        .LEAVES (HALF),
        .IN_W   (PROD_W),
        .LEVELS (LEVELS),
        .ACC_W  (ACC_W)
    ) u_tree (
        .clk  (clk),
        .rst  (rst),
        .leaf (prod),
        .root (root)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe_q <= '0;
            dout    <= '0;
        end else begin
            vpipe_q <= {vpipe_q[LAT-2:0], din_vld};
            dout    <= OUT_W'(root);
        end
    end

    assign dout_vld = vpipe_q[LAT-1];

endmodule

// File: rtl/symfir_chk.sv
module symfir_chk #(
    parameter int LAT   = 9,
    parameter int OUT_W = 38
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    din_vld,
    input logic signed [OUT_W-1:0] dout,
    input logic                    dout_vld
);

    logic [LAT-1:0] shadow_q;
    int             since_rst_q;
    int             idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q    <= '0;
            since_rst_q <= 0;
            idle_q      <= 0;
        end else begin
            shadow_q    <= {shadow_q[LAT-2:0], din_vld};
            since_rst_q <= (since_rst_q < LAT) ? since_rst_q + 1 : since_rst_q;
            idle_q      <= din_vld ? 0 : ((idle_q < LAT) ? idle_q + 1 : idle_q);
        end
    end

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        dout_vld == shadow_q[LAT-1]); // R1

    AST_NO_EARLY_VLD: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> since_rst_q >= LAT); // R1

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!dout_vld && dout == '0)); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (idle_q >= LAT) |-> $stable(dout)); // R9

endmodule

bind symfir_top symfir_chk #(
    .LAT   (LAT),
    .OUT_W (OUT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .din_vld  (din_vld),
    .dout     (dout),
    .dout_vld (dout_vld)
);

// File: tb/symfir_top_bench.sv
module symfir_top_bench;

    localparam int TAPS = 60;
    localparam int HALF = TAPS / 2;
    localparam int LAT  = 9;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] din = '0;
    logic               din_vld = 1'b0;
    logic signed [37:0] dout;
    logic               dout_vld;

    always #5 clk = ~clk;

    symfir_top u_symfir_top (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .din_vld  (din_vld),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    int      checks = 0;
    int      errors = 0;
    int      cyc    = 0;
    longint  hist [TAPS];
    longint  exp_q [$];
    int      exp_t [$];
    longint  cap_q [$];
    bit      capture = 1'b0;
    string   tag = "R6";

    function automatic longint coef(input int k);
        int i;
        i = (k < HALF) ? k : TAPS - 1 - k;
        if (i == 0) return -1;
        if (i == HALF - 1) return 10773;
        return longint'(((97 * i * i + 331 * i + 17) % 4097) - 2048);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic step(input logic signed [15:0] d, input logic v);
        longint y;
        @(negedge clk);
        cyc++;
        if (dout_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {tag, " unexpected dout_vld"}, 1, 0);
            end else begin
                longint e;
                int     t;
                e = exp_q.pop_front();
                t = exp_t.pop_front();
                check(longint'(dout) == e, tag, longint'(dout), e);
                check(cyc - t == LAT, "R1 latency", cyc - t, LAT);
                if (capture) cap_q.push_back(longint'(dout));
            end
        end
        din     = d;
        din_vld = v;
        if (v) begin
            for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'(d);
            y = 0;
            for (int k = 0; k < TAPS; k++) y += coef(k) * hist[k];
            exp_q.push_back(y);
            exp_t.push_back(cyc);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst     = 1'b1;
        din_vld = 1'b0;
        din     = 16'sh1234;
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
        exp_q.delete();
        exp_t.delete();
        repeat (3) @(negedge clk);
        check(dout == '0 && dout_vld == 1'b0, "R6 reset state", longint'(dout) + dout_vld, 0);
        rst = 1'b0;
    endtask

    task automatic flush();
        for (int n = 0; n < LAT + 3; n++) step(16'(n * 77), 1'b0);
        check(exp_q.size() == 0, {tag, " drained"}, exp_q.size(), 0);
    endtask

    initial begin
        #500us;
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < TAPS; k++) hist[k] = 0;
        repeat (2) @(negedge clk);
        do_reset();

        // R2 / R3: impulse response
        tag = "R2 impulse";
        capture = 1'b1;
        step(16'sd1, 1'b1);
        for (int n = 0; n < TAPS + 2; n++) step(16'sd0, 1'b1);
        flush();
        capture = 1'b0;
        check(cap_q.size() >= TAPS, "R2 impulse length", cap_q.size(), TAPS);
        if (cap_q.size() >= TAPS) begin
            check(cap_q[0] == -1, "R3 outer tap", cap_q[0], -1);
            check(cap_q[HALF-1] == 10773 && cap_q[HALF] == 10773, "R3 centre taps", cap_q[HALF], 10773);
            for (int k = 0; k < HALF; k++)
                check(cap_q[k] == cap_q[TAPS-1-k], "R3 symmetry", cap_q[k], cap_q[TAPS-1-k]);
            check(cap_q[TAPS] == 0, "R2 tail zero", cap_q[TAPS], 0);
        end

        // R4: extreme histories
        tag = "R4 full precision";
        for (int n = 0; n < TAPS + 4; n++) step(-16'sd32768, 1'b1);
        for (int n = 0; n < TAPS + 4; n++) step(16'sd32767, 1'b1);
        for (int n = 0; n < TAPS; n++) step((n % 2) ? 16'sd32767 : -16'sd32768, 1'b1);
        flush();

        // R7 / R8: random back-to-back stream
        tag = "R8 random back-to-back R7";
        for (int n = 0; n < 300; n++) step(16'($urandom), 1'b1);
        flush();

        // R5: gapped stream with junk on idle cycles
        tag = "R5 gapped stream";
        for (int n = 0; n < 400; n++) step(16'($urandom), 1'($urandom % 2));
        flush();

        // R9 / R5: idle output holds while din toggles
        tag = "R9 idle hold";
        for (int n = 0; n < 40; n++) step(16'($urandom), 1'b1);
        flush();
        begin
            longint held;
            held = longint'(dout);
            for (int n = 0; n < 12; n++) begin
                step(16'($urandom), 1'b0);
                check(longint'(dout) == held && !dout_vld, "R9 R5 output held", longint'(dout), held);
            end
        end

        // R6: reset mid-stream, then zero history
        tag = "R6 after reset";
        for (int n = 0; n < 20; n++) step(16'($urandom), 1'b1);
        do_reset();
        capture = 1'b1;
        cap_q.delete();
        step(16'sd3, 1'b1);
        for (int n = 0; n < TAPS; n++) step(16'sd0, 1'b1);
        flush();
        capture = 1'b0;
        check(cap_q.size() > 0 && cap_q[0] == -3, "R6 zero history", cap_q[0], -3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule